// File: doc/BRIEF.md
# Message Match/Mask Event Filter

This block watches a stream of interconnect messages, one per cycle when valid, and raises a one-cycle event pulse for every message whose fields agree with a programmable pattern. The pattern covers two 4-bit opcodes (one per direction), two 4-bit message-class codes (one per direction) and a 44-bit cache-line address. A second register of identical layout selects which pattern bits are don't-care. Both registers are loaded through a simple write port that picks the target with a select bit.

Each event pulse advances a wrapping event counter. A sticky overflow flag records that the counter has rolled over, and software clears it with a dedicated clear input. The block is meant to sit beside a performance-monitoring counter bank, so that traffic can be qualified by opcode, class and address before it is counted.

Top module: `msg_event_filter`

## Requirements
- R1: After reset the event pulse, the counter and the overflow flag are zero, and both pattern registers are zero, so only a message whose every field and address bit is zero produces a pulse.
- R2: The 60-bit pattern packs the line address in bits 43:0, the inbound class in 47:44, the outbound class in 51:48, the inbound opcode in 55:52 and the outbound opcode in 59:56. The line address is physical address bits 49:6, which is the only part of the address the message port carries.
- R3: A mask bit of 1 makes the matching pattern bit a don't-care; a mask bit of 0 demands equality. With the mask all zero only an exact match fires; with the mask all ones every valid message fires.
- R4: The mask register uses the same bit layout as the match register; a write with `cfg_sel` = 1 loads the mask, with `cfg_sel` = 0 the match pattern.
- R5: The event pulse is registered: it is high in the cycle after a valid matching message is sampled, for exactly one cycle per such message, and never follows a cycle with `msg_valid` low.
- R6: A register write in the same cycle as a message does not affect that message; it applies from the next message onward.
- R7: The class fields are compared as plain 4-bit codes, so every class code is told apart: home request 0000, home response 0001, NDR 0010, snoop 0011, NCS 0100, NCB 1100, DRS 1110.
- R8: The event counter (`CNT_W` bits, 48 by default) advances by one in the cycle after each event pulse, holds otherwise, and wraps from all ones to zero.
- R9: The overflow flag is set by a counter wrap and stays set until `ovf_clr`; when a wrap and a clear fall in the same cycle, the wrap wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 match pattern, 1 mask |
| cfg_wdata | input | 60 | Write data, layout per R2 |
| msg_valid | input | 1 | Message present this cycle |
| msg_opc_tx | input | 4 | Outbound opcode |
| msg_opc_rx | input | 4 | Inbound opcode |
| msg_cls_tx | input | 4 | Outbound message class |
| msg_cls_rx | input | 4 | Inbound message class |
| msg_paddr | input | 44 | Physical address bits 49:6 |
| ovf_clr | input | 1 | Clears the overflow flag |
| hit_pulse | output | 1 | One-cycle event pulse |
| evt_count | output | CNT_W | Event counter |
| evt_ovf | output | 1 | Sticky counter overflow flag |

## Verification
A message sampled at clock edge k shows its pulse after edge k and the counter moves one edge later, after k+1; a write at edge k governs messages sampled from edge k+1. The bench drives every input on the falling edge and reads the pulse on the very next falling edge and the counter on the one after, so each check lands in the cycle its result is due. The wrap and clear tests run the counter at 8 bits and time the clear to land on the same edge as the wrapping increment.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

  localparam int OPC_W      = 4;
  localparam int CLS_W      = 4;
  localparam int LINE_LSB   = 6;
  localparam int PADDR_MSB  = 49;
  localparam int LINE_W     = PADDR_MSB - LINE_LSB + 1;
  localparam int PAT_W      = 2 * OPC_W + 2 * CLS_W + LINE_W;
  localparam int NUM_FIELDS = 5;

  typedef struct packed {
    logic [OPC_W-1:0]  opc_tx;
    logic [OPC_W-1:0]  opc_rx;
    logic [CLS_W-1:0]  cls_tx;
    logic [CLS_W-1:0]  cls_rx;
    logic [LINE_W-1:0] line;
  } pattern_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_HOME_REQ  = 4'b0000,
    CLS_HOME_RSP  = 4'b0001,
    CLS_NDR       = 4'b0010,
    CLS_SNOOP     = 4'b0011,
    CLS_NCS       = 4'b0100,
    CLS_NCB       = 4'b1100,
    CLS_DRS       = 4'b1110
  } msg_cls_e;

  // Field index 0 is the line address, then the four 4-bit fields upward.
  function automatic int fld_w(input int idx);
    return (idx == 0) ? LINE_W : OPC_W;
  endfunction

  function automatic int fld_lo(input int idx);
    return (idx == 0) ? 0 : LINE_W + OPC_W * (idx - 1);
  endfunction

endpackage

// File: rtl/mmf_rst_sync.sv
module mmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/mmf_cfg_regs.sv
module mmf_cfg_regs
  import mmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [PAT_W-1:0] wr_data,
  output pattern_t         match_o,
  output pattern_t         mask_o
);

  pattern_t match_q, match_d;
  pattern_t mask_q, mask_d;
  logic     match_en, mask_en;

  always_comb begin
    match_en = wr_en & ~wr_sel;
    mask_en  = wr_en & wr_sel;
    match_d  = pattern_t'(wr_data);
    mask_d   = pattern_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      mask_q  <= '0;
    end else begin
      if (match_en) match_q <= match_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  assign match_o = match_q;
  assign mask_o  = mask_q;

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(match_q) && $stable(mask_q)));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> ($stable(match_q) && (mask_q == $past(wr_data))));

endmodule

// File: rtl/mmf_compare.sv
module mmf_compare
  import mmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  opc_tx_i,
  input  logic [OPC_W-1:0]  opc_rx_i,
  input  logic [CLS_W-1:0]  cls_tx_i,
  input  logic [CLS_W-1:0]  cls_rx_i,
  input  logic [LINE_W-1:0] line_i,
  input  pattern_t          match_i,
  input  pattern_t          mask_i,
  output logic              hit_o
);

  pattern_t             smp;
  logic [PAT_W-1:0]     smp_v, mt_v, mk_v;
  logic [NUM_FIELDS-1:0] fld_hit;
  logic                 hit_d, hit_q;

  always_comb begin
    smp.opc_tx = opc_tx_i;
    smp.opc_rx = opc_rx_i;
    smp.cls_tx = cls_tx_i;
    smp.cls_rx = cls_rx_i;
    smp.line   = line_i;
  end

  assign smp_v = smp;
  assign mt_v  = match_i;
  assign mk_v  = mask_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int LO = fld_lo(f);
    localparam int W  = fld_w(f);
    logic [W-1:0] diff;
    assign diff       = (smp_v[LO +: W] ^ mt_v[LO +: W]) & ~mk_v[LO +: W];
    assign fld_hit[f] = ~|diff;
  end

  always_comb begin
    hit_d = valid_i & (&fld_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R5
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(valid_i));

  // R3
  open_mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (mk_v == '1)) |=> hit_q);

  // R3
  exact_match_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (smp_v == mt_v)) |=> hit_q);

endmodule

// File: rtl/mmf_event_counter.sv
module mmf_event_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  always_comb begin
    wrap    = inc_i & (&count_q);
    count_d = count_q + CNT_W'(1);
    ovf_d   = wrap | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (inc_i) count_q <= count_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(count_q));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R9
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (count_q == '0));

endmodule

// File: rtl/msg_event_filter.sv
module msg_event_filter
  import mmf_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [PAT_W-1:0]        cfg_wdata,
  input  logic                    msg_valid,
  input  logic [OPC_W-1:0]        msg_opc_tx,
  input  logic [OPC_W-1:0]        msg_opc_rx,
  input  logic [CLS_W-1:0]        msg_cls_tx,
  input  logic [CLS_W-1:0]        msg_cls_rx,
  input  logic [PADDR_MSB:LINE_LSB] msg_paddr,
  input  logic                    ovf_clr,
  output logic                    hit_pulse,
  output logic [CNT_W-1:0]        evt_count,
  output logic                    evt_ovf
);

  logic     rst_sync_n;
  pattern_t match_pat, mask_pat;
  logic     hit;

  mmf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mmf_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .match_o (match_pat),
    .mask_o  (mask_pat)
  );

  mmf_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid_i  (msg_valid),
    .opc_tx_i (msg_opc_tx),
    .opc_rx_i (msg_opc_rx),
    .cls_tx_i (msg_cls_tx),
    .cls_rx_i (msg_cls_rx),
    .line_i   (msg_paddr),
    .match_i  (match_pat),
    .mask_i   (mask_pat),
    .hit_o    (hit)
  );

  mmf_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc_i     (hit),
    .ovf_clr_i (ovf_clr),
    .count_o   (evt_count),
    .ovf_o     (evt_ovf)
  );

  assign hit_pulse = hit;

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit_pulse && !$past(msg_valid, 2)) |=> !hit_pulse || $past(msg_valid));

endmodule

// File: tb/msg_event_filter_tb_top.sv
module msg_event_filter_tb_top;

  localparam int TB_CNT_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [59:0]         cfg_wdata = '0;
  logic                msg_valid = 1'b0;
  logic [3:0]          msg_opc_tx = '0, msg_opc_rx = '0, msg_cls_tx = '0, msg_cls_rx = '0;
  logic [49:6]         msg_paddr = '0;
  logic                ovf_clr = 1'b0;
  logic                hit_pulse;
  logic [TB_CNT_W-1:0] evt_count;
  logic                evt_ovf;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msg_event_filter #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_opc_tx(msg_opc_tx),
    .msg_opc_rx(msg_opc_rx), .msg_cls_tx(msg_cls_tx), .msg_cls_rx(msg_cls_rx),
    .msg_paddr(msg_paddr), .ovf_clr(ovf_clr), .hit_pulse(hit_pulse),
    .evt_count(evt_count), .evt_ovf(evt_ovf)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_fields(input logic [59:0] p);
    {msg_opc_tx, msg_opc_rx, msg_cls_tx, msg_cls_rx, msg_paddr} = p;
  endtask

  // Drive one message; returns the pulse seen one edge later.
  task automatic send_pat(input logic [59:0] p, output logic hit);
    put_fields(p);
    msg_valid = 1'b1;
    @(negedge clk);
    hit = hit_pulse;
    msg_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [59:0] p, input logic exp);
    logic h;
    send_pat(p, h);
    check(req, h, exp);
  endtask

  task automatic write_reg(input logic sel, input logic [59:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  localparam logic [59:0] PAT_A = {4'h5, 4'hA, 4'h3, 4'hE, 44'h0_1234_5678_9AB};

  task automatic t_reset;
    check("R1 pulse after reset", hit_pulse, 0);
    check("R1 count after reset", evt_count, 0);
    check("R1 ovf after reset", evt_ovf, 0);
    expect_hit("R1 all-zero message hits", 60'h0, 1);
    expect_hit("R1 nonzero address misses", 60'h1, 0);
    expect_hit("R1 nonzero opcode misses", {4'h1, 56'h0}, 0);
  endtask

  task automatic t_layout;
    int lows[6] = '{56, 52, 48, 44, 0, 43};
    write_reg(1'b0, PAT_A);
    expect_hit("R2 exact pattern hits", PAT_A, 1);
    for (int i = 0; i < 6; i++)
      expect_hit($sformatf("R2 bit %0d flipped misses", lows[i]), PAT_A ^ (60'h1 << lows[i]), 0);
  endtask

  task automatic t_mask;
    write_reg(1'b1, {4'hF, 56'h0});
    expect_hit("R4 masked outbound opcode ignored", {4'h0, PAT_A[55:0]}, 1);
    expect_hit("R3 unmasked inbound opcode compared", PAT_A ^ {4'h0, 4'h1, 52'h0}, 0);
    write_reg(1'b1, 60'h400);
    expect_hit("R3 masked address bit ignored", PAT_A ^ 60'h400, 1);
    expect_hit("R3 neighbour address bit compared", PAT_A ^ 60'h800, 0);
    write_reg(1'b1, '1);
    expect_hit("R3 full mask hits anything", 60'hFED_CBA9_8765_4321, 1);
    write_reg(1'b1, '0);
    expect_hit("R3 zero mask needs exact", 60'hFED_CBA9_8765_4321, 0);
  endtask

  task automatic t_class;
    logic [3:0] codes[7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b1100, 4'b1110};
    write_reg(1'b0, {12'h0, 4'b1110, 44'h0});
    write_reg(1'b1, ~{12'h0, 4'hF, 44'h0});
    for (int i = 0; i < 7; i++)
      expect_hit($sformatf("R7 inbound class %b vs 1110", codes[i]),
                 {12'h9A7, codes[i], 44'h0_0F0F_0F0F_0FF}, codes[i] == 4'b1110);
    write_reg(1'b1, '0);
  endtask

  task automatic t_pulse;
    write_reg(1'b0, PAT_A);
    put_fields(PAT_A);
    msg_valid = 1'b0;
    @(negedge clk);
    check("R5 no pulse without valid", hit_pulse, 0);
    expect_hit("R5 pulse one cycle after message", PAT_A, 1);
    @(negedge clk);
    check("R5 pulse lasts one cycle", hit_pulse, 0);
    msg_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check($sformatf("R5 back-to-back pulse %0d", i), hit_pulse, 1);
    end
    msg_valid = 1'b0;
    @(negedge clk);
    check("R5 pulse ends with burst", hit_pulse, 0);
  endtask

  task automatic t_same_cycle;
    logic [59:0] pat_b = PAT_A ^ {8'h0, 4'h7, 48'h0};
    logic h;
    put_fields(PAT_A);
    msg_valid = 1'b1;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = pat_b;
    @(negedge clk);
    h = hit_pulse;
    msg_valid = 1'b0; cfg_we = 1'b0;
    check("R6 message uses old pattern", h, 1);
    expect_hit("R6 new pattern applies next", pat_b, 1);
    expect_hit("R6 old pattern retired", PAT_A, 0);
  endtask

  task automatic t_count;
    logic [TB_CNT_W-1:0] c0;
    @(negedge clk);
    @(negedge clk);
    c0 = evt_count;
    write_reg(1'b0, PAT_A);
    expect_hit("R8 counted message", PAT_A, 1);
    check("R8 count not yet moved in pulse cycle", evt_count, c0);
    @(negedge clk);
    check("R8 count moves one cycle after pulse", evt_count, c0 + 8'd1);
    for (int i = 0; i < 4; i++) begin
      expect_hit("R8 hit", PAT_A, 1);
      expect_hit("R8 miss", PAT_A ^ 60'h2, 0);
    end
    @(negedge clk);
    check("R8 only matches counted", evt_count, c0 + 8'd5);
  endtask

  task automatic burst(input int n);
    put_fields(PAT_A);
    msg_valid = 1'b1;
    repeat (n) @(negedge clk);
    msg_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wrap;
    int c;
    logic h;
    write_reg(1'b0, PAT_A);
    c = int'(evt_count);
    burst(255 - c);
    check("R8 counter at all ones", evt_count, 8'hFF);
    check("R9 no ovf before wrap", evt_ovf, 0);
    burst(1);
    check("R8 counter wraps to zero", evt_count, 0);
    check("R9 ovf set on wrap", evt_ovf, 1);
    burst(3);
    check("R9 ovf sticky", evt_ovf, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9 ovf cleared", evt_ovf, 0);
    burst(252);
    check("R8 counter at all ones again", evt_count, 8'hFF);
    send_pat(PAT_A, h);
    check("R8 wrapping pulse", h, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9 wrap beats clear", evt_ovf, 1);
    check("R8 second wrap to zero", evt_count, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    t_mask();
    t_class();
    t_pulse();
    t_same_cycle();
    t_count();
    t_wrap();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule